// File: doc/BRIEF.md
# Keyed configuration item reader

This block gives boot firmware read access to a fixed table of configuration items through two register ports. A 2-byte write to the control port loads a 16-bit key that chooses an item; reads of the data port then return that item's bytes as a stream. Each read asks for 1 to `W_BYTES` bytes. The item's bytes are packed big-endian into the low bytes of the result, and the block keeps a running byte offset so that each read continues where the previous one stopped.

The items are held in two banks, normal and architecture-local, of `NUM_FIXED + NUM_SLOTS` entries each. Both the contents and the lengths are computed from parameters at elaboration. Key bit 14 chooses the bank and key bits 13:0 form the entry index. An index outside the table moves the reader into an invalid state, and every read in that state returns zeros. A parameter `COMBINED` selects a single-port variant: in that variant the access size alone tells a selector write from a data read.

The control is one state machine with three states:
- `ST_IDLE` accepts accesses.
- `ST_SHIFT` moves one item byte per cycle into the result.
- `ST_RESP` presents the result for one cycle.

The state machine has three transitions:
- `ST_IDLE` to `ST_SHIFT` on an accepted data read.
- `ST_SHIFT` to `ST_RESP` when the last requested byte has been shifted in.
- `ST_RESP` to `ST_IDLE` unconditionally.

A selector write completes in `ST_IDLE` and does not leave that state. Any access presented while `busy` is high is ignored.

Top module: `cfg_item_reader`

## Requirements
- R1: After reset the selected key is 0, the offset is 0, and `busy`, `rd_valid` and `sel_strobe` are low. A 4-byte read then returns the signature item `0x43464758`.
- R2: An accepted selector write always clears the byte offset, whether the key is valid or not. `sel_strobe` is high for exactly the one cycle after the accepting edge, and only when the key is valid.
- R3: The entry index is key bits 13:0. Key bit 14 chooses bank 1 over bank 0. Key bit 15 has no effect.
- R4: A key whose bits 13:0 are at or above `NUM_FIXED + NUM_SLOTS` makes the entry invalid. Every read in the invalid state returns all zeros.
- R5: A data read of N bytes puts the next item byte at bits `8N-1:8N-8`, the following bytes below it, and zeros above bit `8N-1`. `rd_valid` is high for one cycle, following the N-th rising edge after the accepting edge, and `rd_data` carries the result in that cycle.
- R6: Byte positions at or beyond the item length read as zero and do not advance the offset. A read that runs past the end is zero-padded on the right.
- R7: Writes to the data port are ignored. A read after such a write continues at the offset reached before it.
- R8: In the separate-port variant (`COMBINED=0`), `acc_port=1` is the control port and `acc_port=0` is the data port. A control write is accepted only with size 2. Control writes of any other size change neither the key nor the offset.
- R9: In the combined variant (`COMBINED=1`), `acc_port` is ignored. A size-1 read is a data read, a size-2 write is a selector write, and a size-1 write is ignored.
- R10: Item e of bank b is `(e + 5b) mod (MAX_LEN+1)` bytes long, except bank 0 entries 0 and 1, which are 4 bytes long. Byte p of such an item is `{b, e[2:0], p[3:0]} XOR 0xA5`.
- R11: Bank 0 entry 1 is the ID item. Its byte 0 is `0x01` with bit 1 set when `DMA_PRESENT` is 1, and its other three bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request, one cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 1 | 1 = control port, 0 = data port (ignored when COMBINED=1) |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 16 | Write data; the key on a selector write |
| rd_data | output | 8*W_BYTES | Read result, zero when rd_valid is low |
| rd_valid | output | 1 | Read result valid, one cycle |
| busy | output | 1 | A read is in progress |
| sel_strobe | output | 1 | One-cycle pulse after each valid selection |

## Verification
A corrupted offset or bank register shows up on the next data read: the bytes come from the wrong item or from the wrong position in the stream. The error therefore appears in the `rd_data` of the first read after the fault. A wrong invalid flag gives nonzero data where zeros are expected, or zeros where item bytes are expected. A miscounted shift length moves `rd_valid` off its N-th-edge cycle and leaves bytes at the wrong positions, so every read checks both its timing and its value.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

    localparam int KEY_IDX_W = 14;
    localparam int KEY_BANK_BIT = 14;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_RESP  = 2'd2
    } rd_state_e;

    function automatic int item_len(input int bank, input int idx, input int max_len);
        if (bank == 0 && idx < 2) begin
            return 4;
        end
        return (idx + 5 * bank) % (max_len + 1);
    endfunction

    function automatic logic [7:0] item_byte(input int bank, input int idx,
                                             input int pos, input int dma);
        logic [7:0] v;
        if (bank == 0 && idx == 0) begin
            case (pos)
                0: v = 8'h43;
                1: v = 8'h46;
                2: v = 8'h47;
                default: v = 8'h58;
            endcase
        end else if (bank == 0 && idx == 1) begin
            v = (pos == 0) ? (8'h01 | ((dma != 0) ? 8'h02 : 8'h00)) : 8'h00;
        end else begin
            v = {1'(bank), 3'(idx), 4'(pos)} ^ 8'hA5;
        end
        return v;
    endfunction

endpackage

// File: rtl/cfg_item_store.sv
module cfg_item_store #(
    parameter int ENTRIES     = 8,
    parameter int MAX_LEN     = 8,
    parameter int DMA_PRESENT = 1,
    parameter int IDX_W       = 3,
    parameter int OFF_W       = 4
) (
    input  logic             bank,
    input  logic [IDX_W-1:0] idx,
    input  logic [OFF_W-1:0] pos,
    output logic [OFF_W-1:0] len,
    output logic [7:0]       data
);
    import cfg_item_pkg::*;

    localparam int POS_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic [OFF_W-1:0] len_tab  [2][ENTRIES];
    logic [7:0]       byte_tab [2][ENTRIES][MAX_LEN];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
            assign len_tab[b][e] = OFF_W'(item_len(b, e, MAX_LEN));
            for (genvar p = 0; p < MAX_LEN; p++) begin : g_pos
                assign byte_tab[b][e][p] = item_byte(b, e, p, DMA_PRESENT);
            end
        end
    end

    logic             idx_ok;
    logic             pos_ok;
    logic [POS_W-1:0] pos_i;

    assign idx_ok = (int'(idx) < ENTRIES);
    assign pos_ok = (int'(pos) < MAX_LEN);
    assign pos_i  = pos[POS_W-1:0];

    always_comb begin
        len  = '0;
        data = 8'h00;
        if (idx_ok) begin
            len = len_tab[bank][idx];
            if (pos_ok) begin
                data = byte_tab[bank][idx][pos_i];
            end
        end
    end

endmodule

// File: rtl/cfg_access_decode.sv
module cfg_access_decode #(
    parameter int COMBINED = 0,
    parameter int W_BYTES  = 8
) (
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_port,
    input  logic [3:0] acc_size,
    output logic       do_sel,
    output logic       do_rd
);
    if (COMBINED != 0) begin : g_comb
        logic unused_port;
        assign unused_port = acc_port;
        assign do_sel = acc_valid && acc_write && (acc_size == 4'd2);
        assign do_rd  = acc_valid && !acc_write && (acc_size == 4'd1);
    end else begin : g_split
        assign do_sel = acc_valid && acc_write && acc_port && (acc_size == 4'd2);
        assign do_rd  = acc_valid && !acc_write && !acc_port &&
                        (acc_size != 4'd0) && (int'(acc_size) <= W_BYTES);
    end

endmodule

// File: rtl/cfg_item_reader.sv
module cfg_item_reader #(
    parameter int NUM_FIXED   = 4,
    parameter int NUM_SLOTS   = 4,
    parameter int MAX_LEN     = 8,
    parameter int W_BYTES     = 8,
    parameter int DMA_PRESENT = 1,
    parameter int COMBINED    = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic                   acc_port,
    input  logic [3:0]             acc_size,
    input  logic [15:0]            acc_wdata,
    output logic [8*W_BYTES-1:0]   rd_data,
    output logic                   rd_valid,
    output logic                   busy,
    output logic                   sel_strobe
);
    import cfg_item_pkg::*;

    localparam int ENTRIES = NUM_FIXED + NUM_SLOTS;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int OFF_W   = $clog2(MAX_LEN + 1);
    localparam int DW      = 8 * W_BYTES;

    rd_state_e state_q, state_d;

    logic             bank_q;
    logic [IDX_W-1:0] idx_q;
    logic             inv_q;
    logic [OFF_W-1:0] off_q;
    logic [DW-1:0]    acc_q;
    logic [3:0]       cnt_q;
    logic [3:0]       len_q;
    logic             strobe_q;

    logic             do_sel, do_rd;
    logic [OFF_W-1:0] cur_len;
    logic [7:0]       st_byte;
    logic             have_byte;
    logic [7:0]       in_byte;
    logic             key_bad;
    logic             unused_key_msb;

    assign unused_key_msb = acc_wdata[15];
    assign key_bad = (int'(acc_wdata[KEY_IDX_W-1:0]) >= ENTRIES);

    cfg_access_decode #(
        .COMBINED (COMBINED),
        .W_BYTES  (W_BYTES)
    ) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_port  (acc_port),
        .acc_size  (acc_size),
        .do_sel    (do_sel),
        .do_rd     (do_rd)
    );

    cfg_item_store #(
        .ENTRIES     (ENTRIES),
        .MAX_LEN     (MAX_LEN),
        .DMA_PRESENT (DMA_PRESENT),
        .IDX_W       (IDX_W),
        .OFF_W       (OFF_W)
    ) u_store (
        .bank (bank_q),
        .idx  (idx_q),
        .pos  (off_q),
        .len  (cur_len),
        .data (st_byte)
    );

    assign have_byte = !inv_q && (off_q < cur_len);
    assign in_byte   = have_byte ? st_byte : 8'h00;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (do_rd) state_d = ST_SHIFT;
            ST_SHIFT: if (cnt_q == 4'd1) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q   <= 1'b0;
            idx_q    <= '0;
            inv_q    <= 1'b0;
            off_q    <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
            len_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (do_sel) begin
                        bank_q   <= acc_wdata[KEY_BANK_BIT];
                        idx_q    <= acc_wdata[IDX_W-1:0];
                        inv_q    <= key_bad;
                        off_q    <= '0;
                        strobe_q <= !key_bad;
                    end else if (do_rd) begin
                        acc_q <= '0;
                        cnt_q <= acc_size;
                        len_q <= acc_size;
                    end
                end
                ST_SHIFT: begin
                    acc_q <= {acc_q[DW-9:0], in_byte};
                    cnt_q <= cnt_q - 4'd1;
                    if (have_byte) begin
                        off_q <= off_q + 1'b1;
                    end
                end
                ST_RESP: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        rd_valid   = (state_q == ST_RESP);
        rd_data    = rd_valid ? acc_q : '0;
        sel_strobe = strobe_q;
    end

endmodule

// File: rtl/cfg_item_reader_chk.sv
module cfg_item_reader_chk #(
    parameter int DW    = 64,
    parameter int OFF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rd_valid,
    input logic             sel_strobe,
    input logic [DW-1:0]    rd_data,
    input logic [3:0]       len_q,
    input logic             inv_q,
    input logic [OFF_W-1:0] off_q,
    input logic [OFF_W-1:0] cur_len
);
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_strobe |=> !sel_strobe); // R2

    AST_STROBE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_strobe |-> !busy); // R2

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && inv_q) |-> (rd_data == '0)); // R4

    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R5

    AST_RESP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy); // R5

    AST_HIGH_BYTES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data >> {len_q, 3'b000}) == '0)); // R5

    AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q || (off_q <= cur_len)); // R6

endmodule

bind cfg_item_reader cfg_item_reader_chk #(
    .DW    (DW),
    .OFF_W (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .sel_strobe (sel_strobe),
    .rd_data    (rd_data),
    .len_q      (len_q),
    .inv_q      (inv_q),
    .off_q      (off_q),
    .cur_len    (cur_len)
);

// File: tb/cfg_item_reader_test.sv
module cfg_item_reader_test;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 8;
    localparam int MAX_LEN    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        a_valid [2];
    logic        a_write [2];
    logic        a_port  [2];
    logic [3:0]  a_size  [2];
    logic [15:0] a_key   [2];
    logic [63:0] r_data  [2];
    logic        r_valid [2];
    logic        r_busy  [2];
    logic        r_strb  [2];

    cfg_item_reader #(.COMBINED(0)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(a_valid[0]), .acc_write(a_write[0]),
        .acc_port(a_port[0]), .acc_size(a_size[0]), .acc_wdata(a_key[0]),
        .rd_data(r_data[0]), .rd_valid(r_valid[0]), .busy(r_busy[0]), .sel_strobe(r_strb[0]));

    cfg_item_reader #(.COMBINED(1)) uut_comb (
        .clk(clk), .rst_n(rst_n), .acc_valid(a_valid[1]), .acc_write(a_write[1]),
        .acc_port(a_port[1]), .acc_size(a_size[1]), .acc_wdata(a_key[1]),
        .rd_data(r_data[1]), .rd_valid(r_valid[1]), .busy(r_busy[1]), .sel_strobe(r_strb[1]));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_bank [2];
    int m_idx  [2];
    bit m_inv  [2];
    int m_off  [2];

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int e_len(input int b, input int e);
        if (b == 0 && e < 2) return 4;
        return (e + 5 * b) % (MAX_LEN + 1);
    endfunction

    function automatic logic [7:0] e_byte(input int b, input int e, input int p);
        logic [31:0] sig;
        sig = 32'h43464758;
        if (b == 0 && e == 0) return sig[31-8*p -: 8];
        if (b == 0 && e == 1) return (p == 0) ? 8'h03 : 8'h00;
        return {b[0], e[2:0], p[3:0]} ^ 8'hA5;
    endfunction

    function automatic logic [63:0] model_read(input int inst, input int n);
        logic [63:0] v;
        logic [7:0]  bt;
        v = '0;
        for (int i = 0; i < n; i++) begin
            bt = 8'h00;
            if (!m_inv[inst] && m_off[inst] < e_len(m_bank[inst], m_idx[inst])) begin
                bt = e_byte(m_bank[inst], m_idx[inst], m_off[inst]);
                m_off[inst]++;
            end
            v = (v << 8) | 64'(bt);
        end
        return v;
    endfunction

    task automatic issue(input int inst, input bit w, input bit port,
                         input int size, input logic [15:0] key);
        @(negedge clk);
        a_valid[inst] = 1'b1;
        a_write[inst] = w;
        a_port[inst]  = port;
        a_size[inst]  = 4'(size);
        a_key[inst]   = key;
        @(negedge clk);
        a_valid[inst] = 1'b0;
    endtask

    task automatic do_read(input int inst, input bit port, input int n, input string tag);
        logic [63:0] exp;
        int lat;
        exp = model_read(inst, n);
        issue(inst, 1'b0, port, n, 16'h0);
        lat = 0;
        while (!r_valid[inst] && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == n, {tag, " latency"}, 64'(lat), 64'(n));
        check(r_data[inst] == exp, tag, r_data[inst], exp);
    endtask

    task automatic do_sel(input int inst, input bit port, input int size,
                          input logic [15:0] key, input string tag);
        bit accepted;
        bit valid;
        accepted = (size == 2) && (inst == 1 || port);
        valid = 1'b0;
        if (accepted) begin
            m_bank[inst] = int'(key[14]);
            m_idx[inst]  = int'(key[13:0]);
            m_inv[inst]  = (int'(key[13:0]) >= ENTRIES);
            m_off[inst]  = 0;
            valid = !m_inv[inst];
        end
        issue(inst, 1'b1, port, size, key);
        check(r_strb[inst] == valid, {tag, " strobe"}, 64'(r_strb[inst]), 64'(valid));
        @(negedge clk);
        check(r_strb[inst] == 1'b0, {tag, " strobe width"}, 64'(r_strb[inst]), 64'd0);
    endtask

    task automatic do_dwrite(input int inst, input int size, input string tag);
        issue(inst, 1'b1, 1'b0, size, 16'h5A5A);
        check(r_strb[inst] == 1'b0 && r_busy[inst] == 1'b0, tag,
              64'({r_strb[inst], r_busy[inst]}), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] k;
        int op;
        for (int i = 0; i < 2; i++) begin
            a_valid[i] = 0; a_write[i] = 0; a_port[i] = 0; a_size[i] = 0; a_key[i] = 0;
            m_bank[i] = 0; m_idx[i] = 0; m_inv[i] = 0; m_off[i] = 0;
        end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and signature
        check(r_busy[0] == 0 && r_valid[0] == 0 && r_strb[0] == 0, "R1 reset outputs",
              64'({r_busy[0], r_valid[0], r_strb[0]}), 64'd0);
        do_read(0, 1'b0, 4, "R1 signature");
        // R6 past end of signature
        do_read(0, 1'b0, 2, "R6 past end");
        // R11 ID item
        do_sel(0, 1'b1, 2, 16'h0001, "R11 select id");
        do_read(0, 1'b0, 4, "R11 id value");
        // R3 / R10 bank 1 full-length item
        do_sel(0, 1'b1, 2, 16'h4003, "R3 bank1 select");
        do_read(0, 1'b0, 8, "R10 bank1 item");
        // R3 bit 15 ignored
        do_sel(0, 1'b1, 2, 16'h8002, "R3 bit15");
        do_read(0, 1'b0, 3, "R3 bit15 read");
        // R5/R6 partial item with padding
        do_read(0, 1'b0, 1, "R5 one byte");
        // R4 invalid keys
        do_sel(0, 1'b1, 2, 16'h0008, "R4 invalid sel");
        do_read(0, 1'b0, 8, "R4 invalid read");
        do_sel(0, 1'b1, 2, 16'h7FFF, "R4 invalid high");
        do_read(0, 1'b0, 5, "R4 invalid read2");
        // R2 reselect restarts offset
        do_sel(0, 1'b1, 2, 16'h0005, "R2 select");
        do_read(0, 1'b0, 3, "R2 first part");
        do_sel(0, 1'b1, 2, 16'h0005, "R2 reselect");
        do_read(0, 1'b0, 2, "R2 restart");
        // R7 data write ignored
        do_dwrite(0, 1, "R7 data write");
        do_dwrite(0, 2, "R7 data write 2B");
        do_read(0, 1'b0, 2, "R7 continue");
        // R8 wrong control sizes ignored
        do_sel(0, 1'b1, 2, 16'h4001, "R8 select");
        do_read(0, 1'b0, 2, "R8 first part");
        do_sel(0, 1'b1, 1, 16'h0000, "R8 size1 ctl");
        do_sel(0, 1'b1, 4, 16'h0002, "R8 size4 ctl");
        do_read(0, 1'b0, 4, "R8 offset kept");
        // R10 empty item
        do_sel(0, 1'b1, 2, 16'h4004, "R10 empty select");
        do_read(0, 1'b0, 6, "R10 empty read");

        // R9 combined variant
        do_read(1, 1'b1, 1, "R9 comb sig byte");
        do_sel(1, 1'b0, 2, 16'h4002, "R9 comb select");
        do_read(1, 1'b0, 1, "R9 comb read");
        issue(1, 1'b1, 1'b0, 1, 16'h00FF);
        check(r_strb[1] == 0, "R9 comb 1B write", 64'(r_strb[1]), 64'd0);
        do_read(1, 1'b1, 1, "R9 comb continue");

        // constrained random on the separate-port instance
        for (int it = 0; it < 150; it++) begin
            op = int'($urandom % 6);
            case (op)
                0, 1: begin
                    k = 16'($urandom);
                    if ($urandom % 4 != 0) k[13:0] = 14'($urandom % ENTRIES);
                    do_sel(0, 1'b1, 2, k, "R2 random select");
                end
                2, 3, 4: do_read(0, 1'b0, 1 + int'($urandom % 8), "R5 random read");
                default: do_dwrite(0, 1 + int'($urandom % 8), "R7 random write");
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule